// File: doc/BRIEF.md
# Up-Counting Timer Time-Base

This block is the counting core of a general-purpose timer. A free-running prescaler divides the system clock by a programmable ratio. Each prescaler tick advances a counter that climbs from zero to an auto-reload limit and then wraps. A repetition stage thins these wraps, so that an update event is produced only once every N wraps. The update event is the moment at which the block refreshes its working ("shadow") copies of the prescaler ratio, the auto-reload limit and the repetition count from the values software last wrote. A configuration change written while the timer runs therefore takes effect cleanly at a period boundary.

Software drives the block through single-cycle write strobes that share one data bus, together with four level control bits: run enable, update inhibit, software-update flag suppression and reload buffering. A software update strobe restarts the count at once and forces an update. Each update event appears as a one-cycle pulse. Updates also set a sticky flag, which software clears with a write-one-to-clear strobe.

Top module: `upcount_timebase`

## Requirements
- R1: After a synchronous reset, the counter reads 0, the update pulse and flag are 0, and every active and preload value (ratio, limit, repetition) is 0.
- R2: While run enable is 1, the counter advances once every (active ratio + 1) clocks, so a ratio of 0 gives one step per clock. While run enable is 0, neither the prescaler nor the counter moves.
- R3: A step taken at a clock edge where run enable is 1 shows on the count output after that edge. When a step occurs while the count equals the active limit, the count goes to 0 (an overflow) instead of incrementing.
- R4: A ratio write changes only the preload copy. The active ratio takes the preload value only at an update event, so a division period already under way is never changed.
- R5: With reload buffering at 0, a limit write becomes the active limit on the next clock. With reload buffering at 1, the write goes only to the preload copy, which is moved to the active limit at the next update event.
- R6: An overflow produces an update event only when the repetition down-counter is 0. Any other overflow decrements that counter instead. Every update event reloads the counter from the repetition preload, so a repetition write takes effect only from the next update event.
- R7: While update inhibit is 1, no update event occurs: no pulse, no flag set and no shadow refresh. A software update strobe still restarts the counter and the prescaler.
- R8: A software update strobe sets the counter and the prescaler phase to 0 on the next clock. If update inhibit is 0, it also raises an update event. The strobe takes priority over a counter write and over a step in the same cycle.
- R9: When flag suppression is 1, an update raised by the software strobe does not set the flag, but updates caused by overflow still set it. When flag suppression is 0, every update sets the flag.
- R10: The flag stays at 1 until a clear strobe arrives. If a flag set and a clear strobe occur in the same cycle, the flag ends at 1.
- R11: A counter write loads the bus value into the counter on the next clock, takes priority over a step in that cycle, and produces no overflow from that cycle.
- R12: The update pulse is high for exactly the one cycle that follows the clock edge at which an update event took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable level |
| upd_inhibit | input | 1 | Suppresses all update events while 1 |
| sw_flag_mask | input | 1 | Software-raised updates do not set the flag while 1 |
| reload_buffered | input | 1 | Limit writes wait for an update event while 1 |
| wr_count | input | 1 | Strobe: load counter from wr_data |
| wr_ratio | input | 1 | Strobe: write prescaler ratio preload |
| wr_limit | input | 1 | Strobe: write auto-reload limit |
| wr_repeat | input | 1 | Strobe: write repetition preload (low 8 bits) |
| wr_data | input | 16 | Shared write data |
| sw_update | input | 1 | Strobe: restart and force an update |
| flag_clear | input | 1 | Strobe: clear the update flag |
| count | output | 16 | Current counter value |
| update_pulse | output | 1 | One-cycle update event pulse |
| update_flag | output | 1 | Sticky update flag |

## Verification
The bench goes after the points where a buffered value changes while the old value is still in use. It changes the ratio in the middle of a division period, shortens the limit below the current count with buffering on and off, and changes the repetition count between updates. A design that applies any of these at once instead of at an update would shift the wrap and update cycles against the reference model. A design that let software updates set the flag while suppression is on, or that let a same-cycle clear win over a set, would show a wrong flag level. A design that updated shadows under inhibit, or that failed to restart the prescaler phase on a software strobe, would move later updates by a cycle or more.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    localparam int unsigned TB_CNT_W = 16;
    localparam int unsigned TB_PSC_W = 16;
    localparam int unsigned TB_REP_W = 8;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_OVF  = 2'd1,
        UPD_SW   = 2'd2
    } upd_cause_e;

    typedef struct packed {
        logic ev;
        logic flag_set;
    } upd_ctl_t;

    function automatic upd_cause_e pick_cause(input logic sw, input logic ovf_upd);
        if (sw)      return UPD_SW;
        if (ovf_upd) return UPD_OVF;
        return UPD_NONE;
    endfunction

    function automatic upd_ctl_t decide_update(input upd_cause_e cause,
                                               input logic inhibit,
                                               input logic sw_mask);
        upd_ctl_t r;
        r.ev       = !inhibit && (cause != UPD_NONE);
        r.flag_set = r.ev && !(sw_mask && cause == UPD_SW);
        return r;
    endfunction

endpackage

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             restart,
    input  logic             wr,
    input  logic [PSC_W-1:0] wr_data,
    input  logic             upd_ev,
    output logic             tick
);
    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

    logic [PSC_W-1:0] pre_q, act_q, pcnt_q;

    assign tick = enable && !restart && (pcnt_q == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            act_q  <= '0;
            pcnt_q <= '0;
        end else begin
            if (wr)
                pre_q <= wr_data;
            if (upd_ev)
                act_q <= pre_q;
            if (restart)
                pcnt_q <= '0;
            else if (enable)
                pcnt_q <= tick ? '0 : pcnt_q + PSC_ONE;
        end
    end

    // R2
    psc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !restart) |=> $stable(pcnt_q));

    // R4
    psc_active_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_ev |=> $stable(act_q));

endmodule

// File: rtl/tbu_reload.sv
module tbu_reload #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             buffered,
    input  logic             upd_ev,
    output logic [CNT_W-1:0] limit
);
    logic [CNT_W-1:0] pre_q, act_q;

    assign limit = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            act_q <= '0;
        end else begin
            if (wr)
                pre_q <= wr_data;
            if (wr && !buffered)
                act_q <= wr_data;
            else if (upd_ev)
                act_q <= pre_q;
        end
    end

    // R5
    arr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_ev && !wr) |=> $stable(act_q));

endmodule

// File: rtl/tbu_repetition.sv
module tbu_repetition #(
    parameter int unsigned REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REP_W-1:0] wr_data,
    input  logic             ovf,
    input  logic             upd_ev,
    output logic             ovf_upd
);
    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    logic [REP_W-1:0] pre_q, rep_q;

    assign ovf_upd = ovf && (rep_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            rep_q <= '0;
        end else begin
            if (wr)
                pre_q <= wr_data;
            if (upd_ev)
                rep_q <= pre_q;
            else if (ovf && rep_q != '0)
                rep_q <= rep_q - REP_ONE;
        end
    end

    // R6
    rep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovf && !upd_ev) |=> $stable(rep_q));

endmodule

// File: rtl/upcount_timebase.sv
module upcount_timebase
    import timebase_pkg::*;
#(
    parameter int unsigned CNT_W = TB_CNT_W,
    parameter int unsigned PSC_W = TB_PSC_W,
    parameter int unsigned REP_W = TB_REP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             upd_inhibit,
    input  logic             sw_flag_mask,
    input  logic             reload_buffered,
    input  logic             wr_count,
    input  logic             wr_ratio,
    input  logic             wr_limit,
    input  logic             wr_repeat,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sw_update,
    input  logic             flag_clear,
    output logic [CNT_W-1:0] count,
    output logic             update_pulse,
    output logic             update_flag
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             tick, ovf, ovf_upd;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q, flag_q;
    upd_cause_e       cause;
    upd_ctl_t         ctl;

    tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .enable  (run_en),
        .restart (sw_update),
        .wr      (wr_ratio),
        .wr_data (wr_data[PSC_W-1:0]),
        .upd_ev  (ctl.ev),
        .tick    (tick)
    );

    tbu_reload #(.CNT_W(CNT_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_limit),
        .wr_data  (wr_data),
        .buffered (reload_buffered),
        .upd_ev   (ctl.ev),
        .limit    (limit)
    );

    tbu_repetition #(.REP_W(REP_W)) u_rep (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_repeat),
        .wr_data (wr_data[REP_W-1:0]),
        .ovf     (ovf),
        .upd_ev  (ctl.ev),
        .ovf_upd (ovf_upd)
    );

    assign ovf   = tick && !wr_count && (cnt_q == limit);
    assign cause = pick_cause(sw_update, ovf_upd);
    assign ctl   = decide_update(cause, upd_inhibit, sw_flag_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (sw_update)
                cnt_q <= '0;
            else if (wr_count)
                cnt_q <= wr_data;
            else if (tick)
                cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CNT_ONE;
            pulse_q <= ctl.ev;
            if (ctl.flag_set)
                flag_q <= 1'b1;
            else if (flag_clear)
                flag_q <= 1'b0;
        end
    end

    assign count        = cnt_q;
    assign update_pulse = pulse_q;
    assign update_flag  = flag_q;

    // R8
    sw_restart_chk: assert property (@(posedge clk) disable iff (rst)
        sw_update |=> (count == '0));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (update_flag && !flag_clear) |=> update_flag);

    // R7
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        upd_inhibit |=> !update_pulse);

endmodule

// File: tb/upcount_timebase_tb.sv
module upcount_timebase_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 0, upd_inhibit = 0, sw_flag_mask = 0, reload_buffered = 0;
    logic        wr_count = 0, wr_ratio = 0, wr_limit = 0, wr_repeat = 0;
    logic [15:0] wr_data = '0;
    logic        sw_update = 0, flag_clear = 0;
    logic [15:0] count;
    logic        update_pulse, update_flag;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    int cyc_cnt = 0;
    int pulses_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    upcount_timebase u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .upd_inhibit(upd_inhibit),
        .sw_flag_mask(sw_flag_mask), .reload_buffered(reload_buffered),
        .wr_count(wr_count), .wr_ratio(wr_ratio), .wr_limit(wr_limit),
        .wr_repeat(wr_repeat), .wr_data(wr_data), .sw_update(sw_update),
        .flag_clear(flag_clear), .count(count), .update_pulse(update_pulse),
        .update_flag(update_flag)
    );

    // behavioural reference state
    int m_cnt, m_pc, m_pa, m_pp, m_aa, m_ap, m_rp, m_rc;
    bit m_flag, m_pulse;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc_cnt);
        end
    endtask

    always @(posedge clk) begin
        bit step, wrap, fire, sw;
        int n_cnt, n_pc;
        cyc_cnt++;
        if (rst) begin
            m_cnt = 0; m_pc = 0; m_pa = 0; m_pp = 0; m_aa = 0; m_ap = 0;
            m_rp = 0; m_rc = 0; m_flag = 0; m_pulse = 0;
        end else begin
            sw   = sw_update;
            step = run_en && !sw && (m_pc == m_pa);
            wrap = step && !wr_count && (m_cnt == m_aa);
            fire = !upd_inhibit && (sw || (wrap && m_rc == 0));
            n_pc = sw ? 0 : (run_en ? (step ? 0 : (m_pc + 1) & 16'hFFFF) : m_pc);
            if (sw) n_cnt = 0;
            else if (wr_count) n_cnt = wr_data;
            else if (step) n_cnt = (m_cnt == m_aa) ? 0 : (m_cnt + 1) & 16'hFFFF;
            else n_cnt = m_cnt;
            if (fire) m_rc = m_rp;
            else if (wrap && m_rc != 0) m_rc = m_rc - 1;
            if (fire) m_pa = m_pp;
            if (wr_limit && !reload_buffered) m_aa = wr_data;
            else if (fire) m_aa = m_ap;
            if (wr_ratio) m_pp = wr_data;
            if (wr_limit) m_ap = wr_data;
            if (wr_repeat) m_rp = wr_data & 8'hFF;
            if (fire && !(sw && sw_flag_mask)) m_flag = 1;
            else if (flag_clear) m_flag = 0;
            m_pulse = fire;
            m_cnt = n_cnt;
            m_pc = n_pc;
        end
        #5;
        if (!rst && !done) begin
            check(cur_req, count, m_cnt, "count");
            check(cur_req, update_pulse, m_pulse, "pulse");
            check(cur_req, update_flag, m_flag, "flag");
            if (update_pulse) pulses_seen++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_write(input int kind, input int data);
        @(negedge clk);
        wr_data = data[15:0];
        case (kind)
            0: wr_count = 1;
            1: wr_ratio = 1;
            2: wr_limit = 1;
            default: wr_repeat = 1;
        endcase
        @(negedge clk);
        wr_count = 0; wr_ratio = 0; wr_limit = 0; wr_repeat = 0;
    endtask

    task automatic sw_kick();
        @(negedge clk); sw_update = 1;
        @(negedge clk); sw_update = 0;
    endtask

    initial begin
        int p0;
        cycles(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", count, 0, "count after reset");
        check("R1", update_pulse, 0, "pulse after reset");
        check("R1", update_flag, 0, "flag after reset");

        // R2 / R3 / R8: ratio 2, limit 5, load with software update
        cur_req = "R8";
        strobe_write(1, 2);
        strobe_write(2, 5);
        sw_kick();
        check("R8", count, 0, "count after software update");
        check("R8", update_flag, 1, "flag after software update");
        cur_req = "R3";
        @(negedge clk); run_en = 1;
        @(negedge clk);
        check("R3", count, 0, "no step before ratio elapsed");
        cur_req = "R2";
        cycles(60);
        run_en = 0;
        p0 = count;
        cycles(10);
        check("R2", count, p0, "count held while disabled");
        run_en = 1;

        // R4: change ratio mid-run, active only at update
        cur_req = "R4";
        strobe_write(1, 0);
        cycles(40);

        // R5: buffered and immediate limit writes
        cur_req = "R5";
        reload_buffered = 1;
        strobe_write(2, 2);
        cycles(30);
        reload_buffered = 0;
        strobe_write(2, 7);
        @(negedge clk);
        cycles(30);

        // R6: repetition
        cur_req = "R6";
        strobe_write(2, 3);
        strobe_write(3, 2);
        cycles(80);
        strobe_write(3, 0);
        cycles(40);

        // R7: inhibit
        cur_req = "R7";
        upd_inhibit = 1;
        strobe_write(1, 3);
        p0 = pulses_seen;
        cycles(50);
        check("R7", pulses_seen, p0, "no pulses while inhibited");
        sw_kick();
        check("R7", count, 0, "restart under inhibit");
        check("R7", update_pulse, 0, "no pulse for software update under inhibit");
        upd_inhibit = 0;
        cycles(20);

        // R9: flag suppression
        cur_req = "R9";
        sw_flag_mask = 1;
        @(negedge clk); flag_clear = 1;
        @(negedge clk); flag_clear = 0;
        sw_kick();
        check("R9", update_flag, 0, "software update did not set flag");
        check("R9", update_pulse, 1, "software update still pulses");
        cycles(40);
        check("R9", update_flag, 1, "overflow update sets flag");
        sw_flag_mask = 0;

        // R10: set wins over clear
        cur_req = "R10";
        @(negedge clk); sw_update = 1; flag_clear = 1;
        @(negedge clk); sw_update = 0; flag_clear = 0;
        check("R10", update_flag, 1, "set beats clear");
        @(negedge clk); flag_clear = 1; run_en = 0;
        @(negedge clk); flag_clear = 0;
        check("R10", update_flag, 0, "clear strobe");

        // R11: counter write, and software update priority
        cur_req = "R11";
        strobe_write(0, 4);
        check("R11", count, 4, "counter write");
        @(negedge clk); wr_data = 16'd9; wr_count = 1; sw_update = 1;
        @(negedge clk); wr_count = 0; sw_update = 0;
        check("R11", count, 0, "software update beats counter write");
        run_en = 1;

        // R12: random mix
        cur_req = "R12";
        for (int i = 0; i < 4000; i++) begin
            int r;
            @(negedge clk);
            wr_count = 0; wr_ratio = 0; wr_limit = 0; wr_repeat = 0;
            sw_update = 0; flag_clear = 0;
            r = $urandom_range(0, 99);
            wr_data = 16'($urandom_range(0, 7));
            if (r < 3) wr_count = 1;
            else if (r < 6) wr_ratio = 1;
            else if (r < 10) wr_limit = 1;
            else if (r < 13) wr_repeat = 1;
            else if (r < 15) sw_update = 1;
            else if (r < 20) flag_clear = 1;
            if ($urandom_range(0, 49) == 0) reload_buffered = ~reload_buffered;
            if ($urandom_range(0, 59) == 0) sw_flag_mask = ~sw_flag_mask;
            if ($urandom_range(0, 79) == 0) upd_inhibit = ~upd_inhibit;
            run_en = ($urandom_range(0, 9) != 0);
        end
        @(negedge clk);
        wr_count = 0; wr_ratio = 0; wr_limit = 0; wr_repeat = 0;
        sw_update = 0; flag_clear = 0;
        cycles(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule